// File: doc/BRIEF.md
# Serial Shift Register Unit

This block holds one byte and moves it bit by bit across a single serial data pin, most significant bit first. A three-bit mode input picks the direction (in or out) and the source of the shift clock: a tick from an outside interval timer, the block's own clock, or edges arriving on a clock pin. One extra mode sends the same byte out again and again without stopping. When the clock comes from inside the block, the block drives the clock pin with one square-wave period per bit. When the clock comes from outside, the block watches that pin.

A host starts a transfer by writing a new byte or by reading the current one. Either access restarts the bit count. At the end of eight shifts the block raises a one-cycle completion pulse. A separate interrupt block latches that pulse into its flag register. Timer reload, interrupt enables and flag storage sit outside this unit.

Top module: `serial_shifter`

## Requirements
- R1: A write strobe loads the byte and starts a transfer. A read strobe leaves the byte unchanged and also restarts the transfer. `sr_rdata` always shows the current byte.
- R2: In the out modes (mode bit 2 = 1) the register shifts left. `ser_out` carries bit 7, and the bit shifted out re-enters bit 0. After eight shifts the byte is therefore restored.
- R3: In the in modes (codes 001, 010, 011) each shift moves the register left and takes `ser_in` into bit 0. The first bit received ends up in bit 7.
- R4: A transfer ends after exactly eight shifts, with `done` high for one cycle. Shifting then stops until the next access.
- R5: In the timer-driven modes (001, 100, 101) each bit takes two `t2_tick` pulses. The first tick drives `sclk_out` low. The second drives it high and performs the shift.
- R6: In the system-clock modes (010, 110) each bit takes two clock cycles. `done` appears 16 cycles after the cycle in which the write is accepted.
- R7: In the external modes (011, 111) a shift happens on each rising edge of `sclk_in`, seen through a two-stage synchronizer. The shift takes effect on the third clock edge after the pin rises. The block does not drive the clock pin in these modes.
- R8: In free-running mode (100) the byte rotates indefinitely, and `done` is never raised.
- R9: In mode 000 neither pin is driven and the register does not shift. A write still loads it.
- R10: After reset the register is 0x00, `done` is low, `sclk_out` is high and no transfer is running.
- R11: `ser_oe` is high exactly in modes 100 to 111. `sclk_oe` is high exactly in modes 001, 010, 100, 101 and 110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 3 | Shift mode code |
| sr_wr | input | 1 | Register write strobe, one cycle |
| sr_wdata | input | 8 | Byte to load |
| sr_rd | input | 1 | Register read strobe, one cycle |
| sr_rdata | output | 8 | Current register contents |
| t2_tick | input | 1 | Interval timer underflow pulse |
| ser_in | input | 1 | Serial data pin, input side |
| ser_out | output | 1 | Serial data pin, output side |
| ser_oe | output | 1 | Serial data pin output enable |
| sclk_in | input | 1 | Clock pin, input side |
| sclk_out | output | 1 | Clock pin, output side |
| sclk_oe | output | 1 | Clock pin output enable |
| done | output | 1 | One-cycle pulse when eight shifts complete |

## Verification
The bench counts the cycles from an access to `done` in system-clock mode. A design that shifted on every cycle, or one that counted seven or nine bits, would place the pulse at the wrong cycle. Free-running mode is run for twenty bits and must end with the byte rotated by exactly four places and with no pulse at all. A design that stopped after one byte, or that raised the flag on each wrap, fails this check. Input transfers in all three clock sources are compared against the byte sent, which exposes sampling on the wrong tick and bit-order reversal. In disabled mode the bench keeps ticking and expects the byte to stay put with both pins undriven.

// File: rtl/ssr_pkg.sv
`timescale 1ns/1ps
// Shared types for the serial shift register unit.
// Assumes mode codes follow the fixed 3-bit encoding given in the brief.
package ssr_pkg;

    typedef enum logic [2:0] {
        SR_OFF      = 3'd0,
        SR_IN_TMR   = 3'd1,
        SR_IN_SYS   = 3'd2,
        SR_IN_EXT   = 3'd3,
        SR_LOOP_TMR = 3'd4,
        SR_OUT_TMR  = 3'd5,
        SR_OUT_SYS  = 3'd6,
        SR_OUT_EXT  = 3'd7
    } sr_mode_e;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_TIMER = 2'd1,
        SRC_SYS   = 2'd2,
        SRC_EXT   = 2'd3
    } clk_src_e;

    // Map a mode code to the source of its shift clock.
    function automatic clk_src_e src_of(input sr_mode_e m);
        case (m)
            SR_OFF:                              return SRC_NONE;
            SR_IN_TMR, SR_LOOP_TMR, SR_OUT_TMR:  return SRC_TIMER;
            SR_IN_SYS, SR_OUT_SYS:               return SRC_SYS;
            default:                             return SRC_EXT;
        endcase
    endfunction

endpackage

// File: rtl/ssr_clock_src.sv
`timescale 1ns/1ps
// Shift clock source selector.
// Produces a one-cycle tick from the selected source: the timer pulse,
// every system clock, or a synchronised rising edge on the clock pin.
// Assumes the timer pulse is already synchronous to clk.
module ssr_clock_src
    import ssr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  clk_src_e src,
    input  logic     t2_tick,
    input  logic     pin_in,
    output logic     tick,
    output logic     is_ext
);
    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] chain_q;
    logic             rise;

    // Synchroniser chain plus one history stage for edge detection.
    generate
        for (genvar i = 0; i < CHAIN; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= pin_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign rise   = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
    assign is_ext = (src == SRC_EXT);

    // Pick the tick for the current clock source.
    always_comb begin
        case (src)
            SRC_TIMER: tick = t2_tick;
            SRC_SYS:   tick = 1'b1;
            SRC_EXT:   tick = rise;
            default:   tick = 1'b0;
        endcase
    end

    // R7
    ext_tick_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ext && tick) |-> (chain_q[SYNC_STAGES-1] && !chain_q[SYNC_STAGES]));

endmodule

// File: rtl/ssr_sequencer.sv
`timescale 1ns/1ps
// Transfer sequencer: tracks the bit count, the running state and the
// phase of the driven clock pin. It issues a shift strobe and raises a
// completion pulse after the final bit. Assumes start (any access) has
// priority over a tick in the same cycle.
module ssr_sequencer #(
    parameter int BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic enable,
    input  logic ext,
    input  logic loop,
    input  logic tick,
    output logic shift,
    output logic phase,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(BITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q, phase_q, done_q;
    logic             last;

    // Internal modes shift on the second half-period; external on every tick.
    assign shift = busy_q & tick & ~start & (ext | ~phase_q);
    assign last  = shift & (cnt_q == LAST);

    // Bit counter: cleared on access, advanced per shift, wraps after last bit.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (start) cnt_q <= '0;
        else if (shift) cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
    end

    // Running state: set on access when enabled, dropped after a non-loop byte.
    always_ff @(posedge clk) begin
        if (!rst_n)              busy_q <= 1'b0;
        else if (start)          busy_q <= enable;
        else if (last && !loop)  busy_q <= 1'b0;
    end

    // Driven clock pin phase: idles high, toggles on each internal tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                        phase_q <= 1'b1;
        else if (start)                    phase_q <= 1'b1;
        else if (busy_q && tick && !ext)   phase_q <= ~phase_q;
    end

    // Completion pulse for one cycle after the last shift of a byte.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= last & ~loop;
    end

    assign phase = phase_q;
    assign busy  = busy_q;
    assign done  = done_q;

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R4
    done_ends_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_q);
    // R4
    idle_count_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> (cnt_q == '0));
    // R5
    idle_clock_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> phase_q);

endmodule

// File: rtl/ssr_datapath.sv
`timescale 1ns/1ps
// Shift register datapath. Loads a byte on write and shifts left on each
// strobe. In the out direction the outgoing bit re-enters the low end; in
// the in direction the serial pin supplies it. Assumes load and shift
// never both matter in one cycle (load wins).
module ssr_datapath #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] ldata,
    input  logic         shift,
    input  logic         dir_out,
    input  logic         ser_in,
    output logic [W-1:0] sr_q
);
    logic fill;

    assign fill = dir_out ? sr_q[W-1] : ser_in;

    // Register update: load, shift left, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     sr_q <= '0;
        else if (load)  sr_q <= ldata;
        else if (shift) sr_q <= {sr_q[W-2:0], fill};
    end

    // R2
    rotate_keeps_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && dir_out && !load) |=> ($countones(sr_q) == $countones($past(sr_q))));
    // R3
    shift_in_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !dir_out && !load) |=> (sr_q[0] == $past(ser_in)));

endmodule

// File: rtl/serial_shifter.sv
`timescale 1ns/1ps
// Serial shift register unit, top level.
// Decodes the mode, selects the shift clock, sequences eight-bit transfers
// and drives the serial and clock pins. Assumes the mode is only changed
// while no transfer is running, and that the strobes last one cycle.
module serial_shifter
    import ssr_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode,
    input  logic              sr_wr,
    input  logic [DATA_W-1:0] sr_wdata,
    input  logic              sr_rd,
    output logic [DATA_W-1:0] sr_rdata,
    input  logic              t2_tick,
    input  logic              ser_in,
    output logic              ser_out,
    output logic              ser_oe,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              sclk_oe,
    output logic              done
);
    sr_mode_e          mode_e;
    clk_src_e          src;
    logic              tick, is_ext, shift, phase, busy;
    logic              start, dir_out, loop, enable;
    logic [DATA_W-1:0] sr_q;

    // Mode decode into clock source, direction and loop flags.
    always_comb begin
        mode_e  = sr_mode_e'(mode);
        src     = src_of(mode_e);
        dir_out = mode[2];
        loop    = (mode_e == SR_LOOP_TMR);
        enable  = (mode_e != SR_OFF);
        start   = sr_wr | sr_rd;
    end

    ssr_clock_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (src),
        .t2_tick (t2_tick),
        .pin_in  (sclk_in),
        .tick    (tick),
        .is_ext  (is_ext)
    );

    ssr_sequencer #(.BITS(DATA_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .enable (enable),
        .ext    (is_ext),
        .loop   (loop),
        .tick   (tick),
        .shift  (shift),
        .phase  (phase),
        .busy   (busy),
        .done   (done)
    );

    ssr_datapath #(.W(DATA_W)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sr_wr),
        .ldata   (sr_wdata),
        .shift   (shift),
        .dir_out (dir_out),
        .ser_in  (ser_in),
        .sr_q    (sr_q)
    );

    // Pin and register outputs.
    always_comb begin
        sr_rdata = sr_q;
        ser_out  = sr_q[DATA_W-1];
        ser_oe   = dir_out;
        sclk_out = phase;
        sclk_oe  = (src == SRC_TIMER) || (src == SRC_SYS);
    end

    // R9
    off_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0 && !sr_wr) |=> $stable(sr_rdata));
    // R8
    loop_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd4 && $past(mode) == 3'd4) |-> !done);
    // R1
    access_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr || sr_rd) |=> !done);

endmodule

// File: tb/serial_shifter_test.sv
`timescale 1ns/1ps
module serial_shifter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode = 3'd0;
    logic       sr_wr = 1'b0, sr_rd = 1'b0;
    logic [7:0] sr_wdata = 8'h00;
    logic [7:0] sr_rdata;
    logic       t2_tick = 1'b0, ser_in = 1'b0, sclk_in = 1'b0;
    logic       ser_out, ser_oe, sclk_out, sclk_oe, done;

    int vectors = 0, miscompares = 0, cyc = 0, done_cnt = 0;

    always #5 clk = ~clk;

    serial_shifter uut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .sr_wr(sr_wr), .sr_wdata(sr_wdata),
        .sr_rd(sr_rd), .sr_rdata(sr_rdata), .t2_tick(t2_tick), .ser_in(ser_in),
        .ser_out(ser_out), .ser_oe(ser_oe), .sclk_in(sclk_in), .sclk_out(sclk_out),
        .sclk_oe(sclk_oe), .done(done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge.
    int m_sr = 0, m_cnt = 0, m_busy = 0, m_phase = 1, m_done = 0;
    int q1 = 0, q2 = 0, q3 = 0;
    always @(posedge clk) begin
        int md, tk, ext, nd, doshift;
        md = int'(mode);
        nd = 0;
        if (!rst_n) begin
            m_sr = 0; m_cnt = 0; m_busy = 0; m_phase = 1; q1 = 0; q2 = 0; q3 = 0;
        end else begin
            ext = (md == 3 || md == 7) ? 1 : 0;
            if (md == 1 || md == 4 || md == 5) tk = int'(t2_tick);
            else if (md == 2 || md == 6)       tk = 1;
            else if (ext == 1)                 tk = (q2 == 1 && q3 == 0) ? 1 : 0;
            else                               tk = 0;
            if (sr_wr || sr_rd) begin
                if (sr_wr) m_sr = int'(sr_wdata);
                m_cnt = 0; m_busy = (md != 0) ? 1 : 0; m_phase = 1;
            end else if (m_busy == 1 && tk == 1) begin
                doshift = (ext == 1 || m_phase == 0) ? 1 : 0;
                if (ext == 0) m_phase = 1 - m_phase;
                if (doshift == 1) begin
                    if (md >= 4) m_sr = ((m_sr << 1) | (m_sr >> 7)) & 255;
                    else         m_sr = ((m_sr << 1) | int'(ser_in)) & 255;
                    m_cnt++;
                    if (m_cnt == 8) begin
                        m_cnt = 0;
                        if (md != 4) begin m_busy = 0; nd = 1; end
                    end
                end
            end
            q3 = q2; q2 = q1; q1 = int'(sclk_in);
        end
        m_done = nd;
    end

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            int md;
            md = int'(mode);
            chk("R1 R2 R3 sr_rdata", int'(sr_rdata), m_sr);
            chk("R2 ser_out", int'(ser_out), (m_sr >> 7) & 1);
            chk("R4 done", int'(done), m_done);
            chk("R5 sclk_out", int'(sclk_out), m_phase);
            chk("R11 ser_oe", int'(ser_oe), (md >= 4) ? 1 : 0);
            chk("R11 sclk_oe", int'(sclk_oe),
                (md == 1 || md == 2 || md == 4 || md == 5 || md == 6) ? 1 : 0);
            if (done) done_cnt++;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            miscompares++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic wr_byte(input logic [7:0] v);
        @(posedge clk); #1 sr_wr = 1'b1; sr_wdata = v;
        @(posedge clk); #1 sr_wr = 1'b0;
    endtask

    task automatic rd_byte();
        @(posedge clk); #1 sr_rd = 1'b1;
        @(posedge clk); #1 sr_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1 t2_tick = 1'b1;
            @(posedge clk); #1 t2_tick = 1'b0;
            @(posedge clk);
        end
    endtask

    task automatic ext_bit(input logic b);
        @(posedge clk); #1 ser_in = b; sclk_in = 1'b1;
        repeat (4) @(posedge clk);
        #1 sclk_in = 1'b0;
        repeat (4) @(posedge clk);
    endtask

    task automatic set_mode(input logic [2:0] m);
        @(posedge clk); #1 mode = m;
    endtask

    initial begin
        logic [7:0] pat;
        int n, d0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 reset data", int'(sr_rdata), 0);
        chk("R10 reset done", int'(done), 0);
        chk("R10 reset clock pin", int'(sclk_out), 1);

        // R9 disabled: a write loads, nothing shifts, pins undriven
        wr_byte(8'h5A);
        ticks(20);
        @(negedge clk);
        chk("R9 hold in mode 000", int'(sr_rdata), 'h5A);
        chk("R9 ser_oe off", int'(ser_oe), 0);
        chk("R9 sclk_oe off", int'(sclk_oe), 0);

        // R6 R2 system-clock out: done 16 cycles after the write
        set_mode(3'd6);
        d0 = done_cnt;
        wr_byte(8'hA5);
        n = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (done) break;
            n++;
        end
        chk("R6 cycles to done", n, 16);
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk("R2 byte restored", int'(sr_rdata), 'hA5);
        chk("R4 one pulse", done_cnt - d0, 1);

        // R3 R6 system-clock in, then R1 read restarts
        set_mode(3'd2);
        #1 ser_in = 1'b1;
        wr_byte(8'h00);
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk("R3 ones received", int'(sr_rdata), 'hFF);
        #1 ser_in = 1'b0;
        rd_byte();
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk("R1 read restarted transfer", int'(sr_rdata), 'h00);

        // R5 timer out: 15 ticks are not enough, the 16th completes
        set_mode(3'd5);
        d0 = done_cnt;
        wr_byte(8'h81);
        ticks(15);
        @(negedge clk);
        chk("R5 no done after 15 ticks", done_cnt - d0, 0);
        ticks(1);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R5 done after 16 ticks", done_cnt - d0, 1);
        chk("R5 R2 byte restored", int'(sr_rdata), 'h81);

        // R5 R3 timer in with a pattern, one bit per two ticks
        set_mode(3'd1);
        pat = 8'hC6;
        wr_byte(8'h00);
        for (int i = 7; i >= 0; i--) begin
            #1 ser_in = pat[i];
            ticks(2);
        end
        @(negedge clk);
        chk("R5 R3 timer in pattern", int'(sr_rdata), int'(pat));

        // R7 external out: clock pin not driven, eight edges finish
        set_mode(3'd7);
        d0 = done_cnt;
        wr_byte(8'h3C);
        @(negedge clk);
        chk("R7 clock pin undriven", int'(sclk_oe), 0);
        for (int i = 0; i < 8; i++) ext_bit(1'b0);
        @(negedge clk);
        chk("R7 done after 8 edges", done_cnt - d0, 1);
        chk("R7 byte restored", int'(sr_rdata), 'h3C);

        // R7 R3 external in pattern
        set_mode(3'd3);
        pat = 8'h96;
        wr_byte(8'h00);
        for (int i = 7; i >= 0; i--) ext_bit(pat[i]);
        @(negedge clk);
        chk("R7 R3 external in pattern", int'(sr_rdata), int'(pat));

        // R8 free-running: 20 bits rotate by 4, never a done pulse
        set_mode(3'd4);
        d0 = done_cnt;
        wr_byte(8'h01);
        ticks(40);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R8 no done in loop", done_cnt - d0, 0);
        chk("R8 rotated by four", int'(sr_rdata), 'h10);

        // R11 pin enables per mode, after stopping any transfer
        set_mode(3'd0);
        rd_byte();
        for (int m = 0; m < 8; m++) begin
            set_mode(3'(m));
            @(negedge clk);
            chk("R11 ser_oe by mode", int'(ser_oe), (m >= 4) ? 1 : 0);
            chk("R11 sclk_oe by mode", int'(sclk_oe),
                (m == 1 || m == 2 || m == 4 || m == 5 || m == 6) ? 1 : 0);
        end
        set_mode(3'd0);
        repeat (4) @(posedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule